// File: doc/BRIEF.md
# PCM Time Slot Interchanger

This block is a single-stage time switch for 8-bit sign-magnitude PCM samples. Samples arrive in frames of `SLOTS` time slots, one sample per slot. Each arriving sample is stored in a frame buffer at the position of its own slot. In the same transfer the block emits one output sample for that slot. The output sample is taken from the previous frame, at a buffer address that a per-slot routing table supplies. A second routing table names a second talker. When the slot's gain entry asks for it, the two talkers are summed for a three-way call. The gain entry also gates the slot to an idle code and sets a right-shift attenuation for each talker.

A host loads the three per-slot tables (route A, route B, gain) through a plain address, data and write-strobe port. The host writes into shadow copies. Those copies become active at the first transfer of the next frame, so a frame is never switched with a half-updated map.

Both stream sides use valid/ready and move in lockstep. A transfer happens in a cycle where `in_valid` and `out_ready` are both high. In that cycle one input sample is accepted and one output sample is delivered. `in_ready` equals `out_ready`, so the downstream side applies back-pressure to the upstream side. `out_valid` equals `in_valid`, so an output beat exists only while an input beat is offered. Neither side may wait on the other's signal before raising its own.

Top module: `tsi_core`

## Requirements
- R1: After reset, `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. Before the host has loaded any gain entry, every slot outputs the idle code 8'hFF.
- R2: Each transfer advances the slot number by one, wrapping from `SLOTS-1` to 0. A transfer with `in_sof`=1 is slot 0 of a new frame, whatever the count was. Both a wrap and an `in_sof` start a new frame.
- R3: The output of the transfer in slot k is the sample written in slot A[k] of the previous frame, where A is the route-A table. This gives a constant one-frame delay under any permutation.
- R4: A gain entry is 6 bits: bit 5 enable, bit 4 conference, bits 3:2 shift for talker B, bits 1:0 shift for talker A. When bit 5 is 0 the output is 8'hFF, whatever the other bits hold.
- R5: With enable set and conference clear, the output keeps the sign bit (bit 7) of talker A. Its 7-bit magnitude is shifted right by the A shift (0 to 3).
- R6: With enable and conference both set, talker B is the previous-frame sample at route-B entry B[k], shifted by the B shift. The two shifted samples are added as signed values and saturated to ±127. The sum is returned in sign-magnitude, and a zero sum is 8'h00.
- R7: A host write (`host_sel` 0 = route A, 1 = route B, 2 = gain) that reaches the shadow tables before the clock edge of a frame's first transfer governs that frame and the ones after it. It never changes the frame already in progress.
- R8: In a cycle without a transfer, no state changes. A sample offered while `out_ready` is low is not stored, and `in_ready` stays low.
- R9: A host write with `host_sel` = 3 changes no table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Input sample can be taken (equals out_ready) |
| in_data | input | 8 | Input sample, sign-magnitude |
| in_sof | input | 1 | Marks the offered sample as slot 0 |
| out_valid | output | 1 | Output sample present (equals in_valid) |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_data | output | 8 | Switched output sample |
| host_we | input | 1 | Host table write strobe |
| host_sel | input | 2 | Table select: 0 route A, 1 route B, 2 gain, 3 none |
| host_addr | input | $clog2(SLOTS) | Slot whose entry is written |
| host_wdata | input | max($clog2(SLOTS),6) | Entry value (gain uses bits 5:0) |

## Verification
The assertions assume three things about the inputs. `in_sof` and `in_data` matter only in transfer cycles. Host addresses stay below `SLOTS`. Route entries point at slots that exist. The bench keeps to this in three ways. It programs every slot with an in-range route and gain before the first checked frame. It drives the host port only in cycles with `in_valid` low. It changes every input at the falling edge, so values are stable at the sampling edge. One test offers a deliberately wrong sample while `out_ready` is low. Outputs are compared only from the frame after the programmed frame, since the first frame reads a buffer half that was never written.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  localparam int SMP_W = 8;
  localparam int PAD_W = 6;
  localparam logic [SMP_W-1:0] IDLE_CODE = 8'hFF;

  typedef logic [SMP_W-1:0] smp_t;

  // gain entry layout, MSB first
  typedef struct packed {
    logic       en;
    logic       conf;
    logic [1:0] att_b;
    logic [1:0] att_a;
  } pad_t;

  typedef enum logic [1:0] {
    HS_CTLA = 2'd0,
    HS_CTLB = 2'd1,
    HS_PAD  = 2'd2,
    HS_NONE = 2'd3
  } hsel_e;

  function automatic smp_t sm_att(smp_t s, logic [1:0] n);
    return {s[7], s[6:0] >> n};
  endfunction

  function automatic logic signed [8:0] sm_val(smp_t s);
    logic signed [8:0] m;
    m = $signed({2'b00, s[6:0]});
    return s[7] ? -m : m;
  endfunction

  function automatic smp_t sm_sat_sum(smp_t a, smp_t b);
    logic signed [9:0] va;
    logic signed [9:0] vb;
    logic signed [9:0] t;
    logic              neg;
    logic [6:0]        mg;
    va = sm_val(a);
    vb = sm_val(b);
    t  = va + vb;
    if (t > 10'sd127)       t = 10'sd127;
    else if (t < -10'sd127) t = -10'sd127;
    neg = (t < 10'sd0);
    mg  = neg ? 7'(-t) : 7'(t);
    return {neg, mg};
  endfunction

endpackage

// File: rtl/tsi_slot_seq.sv
module tsi_slot_seq #(
  parameter int SLOTS = 256,
  localparam int AW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          sof,
  output logic [AW-1:0] slot_eff,
  output logic          half_eff,
  output logic          boundary
);

  logic [AW-1:0] slot_q;
  logic          hcur_q;
  logic [AW-1:0] slot_nxt;

  assign boundary = sof || (slot_q == '0);
  assign slot_eff = sof ? '0 : slot_q;
  assign half_eff = boundary ? ~hcur_q : hcur_q;
  assign slot_nxt = (slot_eff == AW'(SLOTS-1)) ? '0 : slot_eff + AW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      hcur_q <= 1'b0;
    end else if (step) begin
      slot_q <= slot_nxt;
      hcur_q <= half_eff;
    end
  end

  assert_slot_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !sof && slot_q != AW'(SLOTS-1)) |=> slot_q == $past(slot_q) + AW'(1));

  assert_sof_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && sof) |=> slot_q == AW'(1));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(slot_q) && $stable(hcur_q)));

  assert_half_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && boundary) |=> hcur_q != $past(hcur_q));

endmodule

// File: rtl/tsi_ctrl_bank.sv
module tsi_ctrl_bank #(
  parameter int SLOTS = 256,
  parameter int W = 8,
  localparam int AW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          load,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] shadow [SLOTS];
  logic [W-1:0] active [SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        shadow[i] <= '0;
        active[i] <= '0;
      end
    end else begin
      if (wr_en) shadow[wr_addr] <= wr_data;
      if (load)  active <= shadow;
    end
  end

  // the frame's first transfer already sees the new map
  assign rd_data = load ? shadow[rd_addr] : active[rd_addr];

  assert_map_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load ##1 (!load && $stable(rd_addr))) |-> $stable(rd_data));

endmodule

// File: rtl/tsi_info_mem.sv
module tsi_info_mem #(
  parameter int SLOTS = 256,
  localparam int AW = $clog2(SLOTS)
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic                   wr_half,
  input  logic [AW-1:0]          wr_addr,
  input  tsi_pkg::smp_t          wr_data,
  input  logic [AW-1:0]          rd_addr_a,
  input  logic [AW-1:0]          rd_addr_b,
  output tsi_pkg::smp_t          rd_data_a,
  output tsi_pkg::smp_t          rd_data_b
);

  tsi_pkg::smp_t mem [2][SLOTS];

  always_ff @(posedge clk) begin
    if (we) mem[wr_half][wr_addr] <= wr_data;
  end

  // reads always use the half filled during the previous frame
  assign rd_data_a = mem[~wr_half][rd_addr_a];
  assign rd_data_b = mem[~wr_half][rd_addr_b];

endmodule

// File: rtl/tsi_mix.sv
module tsi_mix
  import tsi_pkg::*;
(
  input  pad_t pad,
  input  smp_t smp_a,
  input  smp_t smp_b,
  output smp_t smp_o
);

  always_comb begin
    if (!pad.en)        smp_o = IDLE_CODE;
    else if (!pad.conf) smp_o = sm_att(smp_a, pad.att_a);
    else                smp_o = sm_sat_sum(sm_att(smp_a, pad.att_a), sm_att(smp_b, pad.att_b));
  end

  always_comb begin
    if (pad.en && pad.conf && !smp_a[7] && !smp_b[7])
      assert_sat_pos_R6: assert (smp_o[7] == 1'b0);
    if (pad.en && !pad.conf)
      assert_att_bound_R5: assert (smp_o[6:0] <= smp_a[6:0]);
  end

endmodule

// File: rtl/tsi_core.sv
module tsi_core
  import tsi_pkg::*;
#(
  parameter int SLOTS = 256,
  localparam int AW = $clog2(SLOTS),
  localparam int HW = (AW > PAD_W) ? AW : PAD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_sof,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  input  logic          host_we,
  input  logic [1:0]    host_sel,
  input  logic [AW-1:0] host_addr,
  input  logic [HW-1:0] host_wdata
);

  logic          step;
  logic [AW-1:0] slot_eff;
  logic          half_eff;
  logic          boundary;
  logic          load;
  logic [AW-1:0] route_rd [2];
  logic [PAD_W-1:0] pad_rd;
  smp_t          talk_a;
  smp_t          talk_b;

  assign step      = in_valid && out_ready;
  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign load      = step && boundary;

  tsi_slot_seq #(.SLOTS(SLOTS)) u_seq (
    .clk(clk), .rst_n(rst_n), .step(step), .sof(in_sof),
    .slot_eff(slot_eff), .half_eff(half_eff), .boundary(boundary)
  );

  for (genvar g = 0; g < 2; g++) begin : g_route
    tsi_ctrl_bank #(.SLOTS(SLOTS), .W(AW)) u_route (
      .clk(clk), .rst_n(rst_n),
      .wr_en(host_we && host_sel == 2'(g)),
      .wr_addr(host_addr), .wr_data(host_wdata[AW-1:0]),
      .load(load), .rd_addr(slot_eff), .rd_data(route_rd[g])
    );
  end

  tsi_ctrl_bank #(.SLOTS(SLOTS), .W(PAD_W)) u_pad (
    .clk(clk), .rst_n(rst_n),
    .wr_en(host_we && host_sel == HS_PAD),
    .wr_addr(host_addr), .wr_data(host_wdata[PAD_W-1:0]),
    .load(load), .rd_addr(slot_eff), .rd_data(pad_rd)
  );

  tsi_info_mem #(.SLOTS(SLOTS)) u_info (
    .clk(clk), .we(step), .wr_half(half_eff), .wr_addr(slot_eff), .wr_data(in_data),
    .rd_addr_a(route_rd[0]), .rd_addr_b(route_rd[1]),
    .rd_data_a(talk_a), .rd_data_b(talk_b)
  );

  tsi_mix u_mix (
    .pad(pad_t'(pad_rd)), .smp_a(talk_a), .smp_b(talk_b), .smp_o(out_data)
  );

endmodule

// File: tb/tsi_core_test.sv
module tsi_core_test;

  localparam int SLOTS = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_sof = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       host_we = 1'b0;
  logic [1:0] host_sel = '0;
  logic [7:0] host_addr = '0;
  logic [7:0] host_wdata = '0;

  int  nvec = 0;
  int  nbad = 0;
  bit  done = 1'b0;

  logic [7:0] ma [SLOTS];
  logic [7:0] mb [SLOTS];
  logic [7:0] mp [SLOTS];
  logic [7:0] fdat [6][SLOTS];

  // {route A, route B, gain} for slots 0..11
  localparam logic [23:0] VEC [12] = '{
    24'h28_00_20, 24'hFF_00_21, 24'h03_00_22, 24'h4D_00_23,
    24'h09_00_00, 24'h14_15_30, 24'h1E_1F_35, 24'h32_32_30,
    24'h3C_3D_10, 24'h0B_0C_3F, 24'hFA_05_34, 24'h00_FF_38
  };

  always #4 clk = ~clk;

  tsi_core #(.SLOTS(SLOTS)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .host_we(host_we), .host_sel(host_sel),
    .host_addr(host_addr), .host_wdata(host_wdata)
  );

  function automatic logic [7:0] src(int f, int j);
    return 8'(j * 73 + f * 29 + 11);
  endfunction

  function automatic logic [7:0] model(logic [7:0] pad, logic [7:0] a, logic [7:0] b);
    int ma_i, mb_i, va, vb, s;
    if (!pad[5]) return 8'hFF;
    ma_i = int'(a[6:0]) >> pad[1:0];
    if (!pad[4]) return {a[7], 7'(ma_i)};
    mb_i = int'(b[6:0]) >> pad[3:2];
    va = a[7] ? -ma_i : ma_i;
    vb = b[7] ? -mb_i : mb_i;
    s = va + vb;
    if (s > 127) s = 127;
    if (s < -127) s = -127;
    if (s < 0) return {1'b1, 7'(-s)};
    return {1'b0, 7'(s)};
  endfunction

  function automatic string tag_of(logic [7:0] pad);
    if (!pad[5]) return "R4";
    if (pad[4]) return "R6";
    if (pad[1:0] != 2'd0) return "R5";
    return "R3";
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic host_write(logic [1:0] sel, logic [7:0] addr, logic [7:0] data);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_addr = addr; host_wdata = data;
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic xfer(logic [7:0] d, bit sof, bit chk_en, logic [7:0] exp, string tag);
    @(negedge clk);
    in_valid = 1'b1; in_sof = sof; in_data = d; out_ready = 1'b1;
    #2;
    if (chk_en) begin
      chk(tag, out_data, exp);
      chk("R1", {7'b0, out_valid}, 8'd1);
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  task automatic mid_frame_actions();
    host_write(2'd0, 8'd200, 8'd5);   // R7: pending route change
    host_write(2'd3, 8'd201, 8'd7);   // R9: select 3 ignored
    host_write(2'd2, 8'd202, 8'h00);  // R7: pending idle gain
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h5A; out_ready = 1'b0;
    #2;
    chk("R8", {7'b0, in_ready}, 8'd0);
    chk("R1", {7'b0, out_valid}, 8'd1);
    @(posedge clk); #1;
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk); #2;
    chk("R1", {7'b0, out_valid}, 8'd0);
  endtask

  task automatic run_frame(int f, bit sof0, int nslots, bit check, string ovr);
    logic [7:0] exp;
    string tag;
    for (int j = 0; j < nslots; j++) begin
      exp = 8'h00;
      if (f > 0) exp = model(mp[j], fdat[f-1][ma[j]], fdat[f-1][mb[j]]);
      tag = (ovr != "") ? ovr : tag_of(mp[j]);
      if ((f == 1 || f == 2) && (j == 200 || j == 202)) tag = "R7";
      if (f == 2 && j == 201) tag = "R9";
      if (f == 2 && j == 100) tag = "R8";
      if (f == 1 && j == 100) mid_frame_actions();
      xfer(src(f, j), sof0 && j == 0, check, exp, tag);
      fdat[f][j] = src(f, j);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #2;
    chk("R1", {7'b0, out_valid}, 8'd0);
    chk("R1", {7'b0, in_ready}, 8'd1);
    out_ready = 1'b0; #1;
    chk("R1", {7'b0, in_ready}, 8'd0);
    out_ready = 1'b1;
    xfer(8'h12, 1'b1, 1'b1, 8'hFF, "R1");

    for (int k = 0; k < SLOTS; k++) begin
      ma[k] = (k < 12) ? VEC[k][23:16] : 8'(k);
      mb[k] = (k < 12) ? VEC[k][15:8]  : 8'h00;
      mp[k] = (k < 12) ? VEC[k][7:0]   : 8'h20;
      host_write(2'd0, 8'(k), ma[k]);
      host_write(2'd1, 8'(k), mb[k]);
      host_write(2'd2, 8'(k), mp[k]);
    end

    run_frame(0, 1'b1, SLOTS, 1'b0, "");
    run_frame(1, 1'b1, SLOTS, 1'b1, "");
    ma[200] = 8'd5;
    mp[202] = 8'h00;
    run_frame(2, 1'b1, SLOTS, 1'b1, "");
    run_frame(3, 1'b0, SLOTS, 1'b1, "R2");   // frame start by wrap
    run_frame(4, 1'b1, 10, 1'b1, "R2");      // cut short
    for (int j = 10; j < SLOTS; j++) fdat[4][j] = fdat[2][j];
    run_frame(5, 1'b1, 22, 1'b1, "R2");      // early start marker

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule